// File: doc/BRIEF.md
# Partial Reconfiguration Session Controller

This block is the register front end that a host driver uses to run one partial-reconfiguration session at a time. It sits on a simple 64-bit register bus with one-cycle write strobes and registered read data, and it drives a downstream data queue through start, complete, abort and push strobes. The host first pulses an engine reset and waits for its acknowledge. It then picks a target region, opens a session, streams 32-bit data words and marks the end of the data. Hardware closes the session by itself once the queue has drained.

Faults reported by the queue (operation, CRC, incompatible image, overflow) and bus-protocol misuse detected locally are held as sticky flags. The host clears them by writing ones. A 128-bit interface identifier and a feature header are read-only constants set by parameters. The bitstream decoding, CRC calculation and configuration fabric sit downstream and are not part of this block.

Top module: `prc_ctrl_regs`

## Requirements
- R1: After the synchronous reset, the control, status, error and data offsets all read zero. Read data appears on `bus_rdata` one clock after the cycle in which `bus_rd` is high, and holds until the next read.
- R2: Control bit 0 is the engine-reset request. Bit 4 reads 1 one cycle after the request is seen high and 0 one cycle after it is seen low. `q_abort` pulses for one cycle when the request goes from 0 to 1. While the request is held, the session bits clear, a start written in the same word as the request is ignored, and data writes are not pushed.
- R3: Control bits 9:7 hold a 3-bit region number. A control write stores it and a control read returns it.
- R4: A control write with bit 12 set and bit 0 clear, made while no session is open and reset is not held, sets bit 12 and pulses `q_start` once. During the session, each write to offset 0x18 pulses `q_push` with bits 31:0 of the word on `q_data`.
- R5: A control write with bit 13 set during an open session sets bit 13 and pulses `q_complete`. Bits 12 and 13 both clear FIN_LAT (default 4) clock edges after the first edge at which `q_empty` is seen high while draining.
- R6: Status bit 16 is 1 while a session is open. Bits 22:20 give the phase: 0 idle, 1 reset held, 2 accepting data, 3 draining, 4 finishing. Bits 27:24 read {reset request, reset ack, start, complete}.
- R7: Error flags at offset 0x20 are sticky: bit 0 operation, bit 1 CRC, bit 2 incompatible image, bit 4 queue overflow, each set by a one-cycle input pulse. Writing 1 to a bit clears it, a set in the same cycle wins over the clear, and the flags survive an engine reset.
- R8: Error bit 3 (protocol) is set when a data write arrives while no session is accepting data, or when bit 13 is written while no session is open.
- R9: Offset 0x00 reads the feature-header parameter, 0xA8 reads the low 64 bits of the interface identifier and 0xB0 reads the high 64 bits.
- R10: Reads of any other offset return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| q_start | output | 1 | Session-open strobe to queue |
| q_complete | output | 1 | End-of-data strobe to queue |
| q_abort | output | 1 | Abort strobe on engine reset |
| q_push | output | 1 | Data-word push strobe |
| q_data | output | PUSH_W | Pushed data word |
| q_empty | input | 1 | Queue has drained |
| ev_op_err | input | 1 | Operation-error pulse |
| ev_crc_err | input | 1 | CRC-error pulse |
| ev_incompat | input | 1 | Incompatible-image pulse |
| ev_overflow | input | 1 | Queue-overflow pulse |

## Verification
The checker takes for granted that the bus presents at most one strobe per cycle, so a read and a write, or two writes, never share a cycle. It also assumes the error inputs are plain pulses that need no handshake. The bench drives every access through tasks that raise exactly one strobe for one cycle, and it raises the event inputs on their own or together with an error-clear write when the set-over-clear case is exercised. Queue emptiness is held low and then raised by the bench, so that the draining phase is observed before the finish delay runs.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int BUS_W    = 64;
  localparam int ADDR_W   = 8;
  localparam int REGION_W = 3;
  localparam int ERR_N    = 5;

  localparam logic [ADDR_W-1:0] OFS_HDR  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_DATA = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_ERR  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_IDLO = 8'hA8;
  localparam logic [ADDR_W-1:0] OFS_IDHI = 8'hB0;

  localparam int CB_RST  = 0;
  localparam int CB_ACK  = 4;
  localparam int CB_RGN  = 7;
  localparam int CB_GO   = 12;
  localparam int CB_DONE = 13;

  localparam int SB_BUSY  = 16;
  localparam int SB_PHASE = 20;
  localparam int SB_HOST  = 24;

  localparam int EB_PROTO = 3;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_RST   = 3'd1,
    PH_RUN   = 3'd2,
    PH_DRAIN = 3'd3,
    PH_FIN   = 3'd4
  } prc_phase_e;
endpackage

// File: rtl/prc_seq.sv
module prc_seq
  import prc_pkg::*;
#(
  parameter int REGION_W_P = 3,
  parameter int PUSH_W     = 32,
  parameter int FIN_LAT    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ctl_wr,
  input  logic                  ctl_rst_bit,
  input  logic [REGION_W_P-1:0] ctl_region,
  input  logic                  ctl_go_bit,
  input  logic                  ctl_done_bit,
  input  logic                  dat_wr,
  input  logic [PUSH_W-1:0]     dat_in,
  input  logic                  q_empty,
  output logic                  rst_req,
  output logic                  rst_ack,
  output logic [REGION_W_P-1:0] region,
  output logic                  sess_go,
  output logic                  sess_done,
  output prc_phase_e            phase,
  output logic                  q_start,
  output logic                  q_complete,
  output logic                  q_abort,
  output logic                  q_push,
  output logic [PUSH_W-1:0]     q_data,
  output logic                  proto_err
);
  localparam int CW = (FIN_LAT > 1) ? $clog2(FIN_LAT) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(FIN_LAT - 1);

  logic [CW-1:0] fin_cnt;
  logic          accepting;

  assign accepting = (phase == PH_RUN) && !rst_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req    <= 1'b0;
      rst_ack    <= 1'b0;
      region     <= '0;
      sess_go    <= 1'b0;
      sess_done  <= 1'b0;
      phase      <= PH_IDLE;
      fin_cnt    <= '0;
      q_start    <= 1'b0;
      q_complete <= 1'b0;
      q_abort    <= 1'b0;
      q_push     <= 1'b0;
      q_data     <= '0;
      proto_err  <= 1'b0;
    end else begin
      q_start    <= 1'b0;
      q_complete <= 1'b0;
      q_abort    <= 1'b0;
      q_push     <= 1'b0;
      proto_err  <= dat_wr && !accepting;
      rst_ack    <= rst_req;
      if (ctl_wr) begin
        rst_req <= ctl_rst_bit;
        region  <= ctl_region;
        q_abort <= ctl_rst_bit && !rst_req;
      end
      if (rst_req) begin
        phase     <= PH_RST;
        sess_go   <= 1'b0;
        sess_done <= 1'b0;
      end else begin
        unique case (phase)
          PH_IDLE, PH_RST: begin
            phase <= PH_IDLE;
            if (ctl_wr) begin
              if (ctl_go_bit && !ctl_rst_bit) begin
                sess_go <= 1'b1;
                phase   <= PH_RUN;
                q_start <= 1'b1;
              end else if (ctl_done_bit) begin
                proto_err <= 1'b1;
              end
            end
          end
          PH_RUN: begin
            if (dat_wr) begin
              q_push <= 1'b1;
              q_data <= dat_in;
            end
            if (ctl_wr && ctl_done_bit && !ctl_rst_bit) begin
              sess_done  <= 1'b1;
              phase      <= PH_DRAIN;
              q_complete <= 1'b1;
            end
          end
          PH_DRAIN: begin
            if (q_empty) begin
              phase   <= PH_FIN;
              fin_cnt <= CNT_LOAD;
            end
          end
          PH_FIN: begin
            if (fin_cnt == '0) begin
              phase     <= PH_IDLE;
              sess_go   <= 1'b0;
              sess_done <= 1'b0;
            end else begin
              fin_cnt <= fin_cnt - 1'b1;
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/prc_err.sv
module prc_err #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags
);
  logic [N-1:0] clr_mask;

  assign clr_mask = clr_wr ? clr_vec : '0;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flags[i] <= 1'b0;
      end else if (set_vec[i]) begin
        flags[i] <= 1'b1;
      end else if (clr_mask[i]) begin
        flags[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/prc_ctrl_regs.sv
module prc_ctrl_regs
  import prc_pkg::*;
#(
  parameter int          PUSH_W  = 32,
  parameter int          FIN_LAT = 4,
  parameter logic [63:0] HDR_VAL = 64'h1000_0000_0000_0005,
  parameter logic [63:0] ID_LO   = 64'h0123_4567_89AB_CDEF,
  parameter logic [63:0] ID_HI   = 64'hFEDC_BA98_7654_3210
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  output logic              q_start,
  output logic              q_complete,
  output logic              q_abort,
  output logic              q_push,
  output logic [PUSH_W-1:0] q_data,
  input  logic              q_empty,
  input  logic              ev_op_err,
  input  logic              ev_crc_err,
  input  logic              ev_incompat,
  input  logic              ev_overflow
);
  logic                wr_ctrl, wr_data, wr_err;
  logic                rst_req, rst_ack, sess_go, sess_done, proto_err;
  logic [REGION_W-1:0] region;
  prc_phase_e          phase;
  logic [ERR_N-1:0]    err_flags, err_set;
  logic [BUS_W-1:0]    ctrl_view, stat_view;
  logic                unused_wbits;

  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_data = bus_wr && (bus_addr == OFS_DATA);
  assign wr_err  = bus_wr && (bus_addr == OFS_ERR);
  assign unused_wbits = ^bus_wdata;

  prc_seq #(
    .REGION_W_P (REGION_W),
    .PUSH_W     (PUSH_W),
    .FIN_LAT    (FIN_LAT)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .ctl_wr       (wr_ctrl),
    .ctl_rst_bit  (bus_wdata[CB_RST]),
    .ctl_region   (bus_wdata[CB_RGN +: REGION_W]),
    .ctl_go_bit   (bus_wdata[CB_GO]),
    .ctl_done_bit (bus_wdata[CB_DONE]),
    .dat_wr       (wr_data),
    .dat_in       (bus_wdata[PUSH_W-1:0]),
    .q_empty      (q_empty),
    .rst_req      (rst_req),
    .rst_ack      (rst_ack),
    .region       (region),
    .sess_go      (sess_go),
    .sess_done    (sess_done),
    .phase        (phase),
    .q_start      (q_start),
    .q_complete   (q_complete),
    .q_abort      (q_abort),
    .q_push       (q_push),
    .q_data       (q_data),
    .proto_err    (proto_err)
  );

  always_comb begin
    err_set           = '0;
    err_set[0]        = ev_op_err;
    err_set[1]        = ev_crc_err;
    err_set[2]        = ev_incompat;
    err_set[EB_PROTO] = proto_err;
    err_set[4]        = ev_overflow;
  end

  prc_err #(.N(ERR_N)) u_err (
    .clk     (clk),
    .rst     (rst),
    .set_vec (err_set),
    .clr_wr  (wr_err),
    .clr_vec (bus_wdata[ERR_N-1:0]),
    .flags   (err_flags)
  );

  always_comb begin
    ctrl_view                      = '0;
    ctrl_view[CB_RST]              = rst_req;
    ctrl_view[CB_ACK]              = rst_ack;
    ctrl_view[CB_RGN +: REGION_W]  = region;
    ctrl_view[CB_GO]               = sess_go;
    ctrl_view[CB_DONE]             = sess_done;
    stat_view                      = '0;
    stat_view[SB_BUSY]             = sess_go;
    stat_view[SB_PHASE +: 3]       = phase;
    stat_view[SB_HOST +: 4]        = {rst_req, rst_ack, sess_go, sess_done};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (bus_addr)
        OFS_HDR:  bus_rdata <= HDR_VAL;
        OFS_CTRL: bus_rdata <= ctrl_view;
        OFS_STAT: bus_rdata <= stat_view;
        OFS_ERR:  bus_rdata <= BUS_W'(err_flags);
        OFS_IDLO: bus_rdata <= ID_LO;
        OFS_IDHI: bus_rdata <= ID_HI;
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/prc_chk.sv
module prc_chk
  import prc_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic        rst_req,
  input logic        rst_ack,
  input logic        sess_go,
  input logic        sess_done,
  input logic [2:0]  phase,
  input logic [4:0]  err_flags,
  input logic        q_push,
  input logic        q_abort,
  input logic        q_start
);
  a_r2_ack_blocks_session: assert property (@(posedge clk) disable iff (rst)
    rst_ack |-> (!sess_go && !sess_done));

  a_r2_abort_with_request: assert property (@(posedge clk) disable iff (rst)
    q_abort |-> rst_req);

  a_r4_push_in_session: assert property (@(posedge clk) disable iff (rst)
    q_push |-> (sess_go && !sess_done));

  a_r4_start_opens_run: assert property (@(posedge clk) disable iff (rst)
    q_start |-> (phase == PH_RUN));

  a_r5_done_implies_go: assert property (@(posedge clk) disable iff (rst)
    sess_done |-> sess_go);

  a_r5_go_drops_from_finish: assert property (@(posedge clk) disable iff (rst)
    $fell(sess_go) |-> ($past(phase) == PH_FIN || $past(rst_req)));

  a_r7_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == OFS_ERR) |=> ((err_flags & $past(err_flags)) == $past(err_flags)));
endmodule

bind prc_ctrl_regs prc_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .rst_req   (rst_req),
  .rst_ack   (rst_ack),
  .sess_go   (sess_go),
  .sess_done (sess_done),
  .phase     (phase),
  .err_flags (err_flags),
  .q_push    (q_push),
  .q_abort   (q_abort),
  .q_start   (q_start)
);

// File: tb/sim_prc_ctrl_regs.sv
`timescale 1ns/1ps
module sim_prc_ctrl_regs;
  localparam logic [63:0] HDR  = 64'h2000_0001_0000_0005;
  localparam logic [63:0] IDLO = 64'h1111_2222_3333_4444;
  localparam logic [63:0] IDHI = 64'h5555_6666_7777_8888;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        q_start, q_complete, q_abort, q_push;
  logic [31:0] q_data;
  logic        q_empty = 1'b0;
  logic        ev_op_err = 1'b0, ev_crc_err = 1'b0, ev_incompat = 1'b0, ev_overflow = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prc_ctrl_regs #(.PUSH_W(32), .FIN_LAT(4), .HDR_VAL(HDR), .ID_LO(IDLO), .ID_HI(IDHI)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .q_start(q_start),
    .q_complete(q_complete), .q_abort(q_abort), .q_push(q_push), .q_data(q_data),
    .q_empty(q_empty), .ev_op_err(ev_op_err), .ev_crc_err(ev_crc_err),
    .ev_incompat(ev_incompat), .ev_overflow(ev_overflow));

  // Behavioural reference model
  int          m_ph = 0, m_cnt = 0;
  bit          m_rr = 0, m_ack = 0, m_st = 0, m_cp = 0, m_pp = 0;
  bit [2:0]    m_reg = 0;
  bit [4:0]    m_err = 0;
  bit [63:0]   m_rd = 0;
  bit          e_qs = 0, e_qc = 0, e_qa = 0, e_qp = 0;
  bit [31:0]   e_qd = 0;

  function automatic bit [63:0] ctrl_word(bit rr, bit ack, bit [2:0] rg, bit st, bit cp);
    return (64'(rr)) | (64'(ack) << 4) | (64'(rg) << 7) | (64'(st) << 12) | (64'(cp) << 13);
  endfunction

  always @(posedge clk) begin
    int o_ph;
    bit o_rr, o_pp, perr, wc, wdt;
    bit [4:0] clr, setv;
    o_ph = m_ph; o_rr = m_rr; o_pp = m_pp;
    wc  = bus_wr && bus_addr == 8'h08;
    wdt = bus_wr && bus_addr == 8'h18;
    e_qs = 0; e_qc = 0; e_qa = 0; e_qp = 0;
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_rr = 0; m_ack = 0; m_st = 0; m_cp = 0; m_pp = 0;
      m_reg = 0; m_err = 0; m_rd = 0;
    end else begin
      if (bus_rd) begin
        case (bus_addr)
          8'h00: m_rd = HDR;
          8'h08: m_rd = ctrl_word(m_rr, m_ack, m_reg, m_st, m_cp);
          8'h10: m_rd = (64'(m_st) << 16) | (64'(m_ph) << 20) |
                        (64'({m_rr, m_ack, m_st, m_cp}) << 24);
          8'h20: m_rd = 64'(m_err);
          8'hA8: m_rd = IDLO;
          8'hB0: m_rd = IDHI;
          default: m_rd = 0;
        endcase
      end
      setv = {ev_overflow, o_pp, ev_incompat, ev_crc_err, ev_op_err};
      clr  = (bus_wr && bus_addr == 8'h20) ? bus_wdata[4:0] : 5'd0;
      m_err = (m_err & ~clr) | setv;
      m_ack = o_rr;
      perr = wdt && (o_ph != 2 || o_rr);
      if (wc) begin
        m_rr = bus_wdata[0];
        m_reg = bus_wdata[9:7];
        e_qa = bus_wdata[0] && !o_rr;
      end
      if (o_rr) begin
        m_ph = 1; m_st = 0; m_cp = 0;
      end else if (o_ph <= 1) begin
        m_ph = 0;
        if (wc) begin
          if (bus_wdata[12] && !bus_wdata[0]) begin m_st = 1; m_ph = 2; e_qs = 1; end
          else if (bus_wdata[13]) perr = 1;
        end
      end else if (o_ph == 2) begin
        if (wdt) begin e_qp = 1; e_qd = bus_wdata[31:0]; end
        if (wc && bus_wdata[13] && !bus_wdata[0]) begin m_cp = 1; m_ph = 3; e_qc = 1; end
      end else if (o_ph == 3) begin
        if (q_empty) begin m_ph = 4; m_cnt = 3; end
      end else begin
        if (m_cnt == 0) begin m_ph = 0; m_st = 0; m_cp = 0; end
        else m_cnt = m_cnt - 1;
      end
      m_pp = perr;
    end
  end

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 rdata vs model", bus_rdata, m_rd);
      chk("R4 q_start vs model", 64'(q_start), 64'(e_qs));
      chk("R5 q_complete vs model", 64'(q_complete), 64'(e_qc));
      chk("R2 q_abort vs model", 64'(q_abort), 64'(e_qa));
      chk("R4 q_push vs model", 64'(q_push), 64'(e_qp));
      if (e_qp) chk("R4 q_data vs model", 64'(q_data), 64'(e_qd));
    end
  end

  task automatic wr(logic [7:0] a, logic [63:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [63:0] v);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    v = bus_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        done = 1;
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<20000", cycles);
        summary();
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] v;
    int hold;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    rd(8'h08, v); chk("R1 ctrl after reset", v, 0);
    rd(8'h10, v); chk("R1 status after reset", v, 0);
    rd(8'h20, v); chk("R1 error after reset", v, 0);
    rd(8'h18, v); chk("R1 data offset reads zero", v, 0);
    // R9 identifiers
    rd(8'h00, v); chk("R9 header", v, HDR);
    rd(8'hA8, v); chk("R9 id low word", v, IDLO);
    rd(8'hB0, v); chk("R9 id high word", v, IDHI);
    // R10 unmapped
    rd(8'h28, v); chk("R10 unmapped read", v, 0);
    wr(8'h28, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(8'hA8, 64'h1234);
    rd(8'h08, v); chk("R10 ctrl untouched", v, 0);
    rd(8'h20, v); chk("R10 error untouched", v, 0);
    rd(8'hA8, v); chk("R10 id not writable", v, IDLO);

    // R2 reset handshake
    wr(8'h08, 64'h1);
    rd(8'h08, v); chk("R2 request seen, ack pending", v, 64'h01);
    rd(8'h08, v); chk("R2 ack asserted", v, 64'h11);
    rd(8'h10, v); chk("R6 status with reset held", v, 64'h0C10_0000);
    wr(8'h08, 64'h1001);
    idle(1);
    rd(8'h08, v); chk("R2 start ignored under reset", v, 64'h11);
    wr(8'h08, 64'h0);
    rd(8'h08, v); chk("R2 ack one cycle late", v, 64'h10);
    rd(8'h08, v); chk("R2 ack dropped", v, 64'h0);

    // R3/R4 session open
    wr(8'h08, 64'h1280);
    idle(1);
    rd(8'h08, v); chk("R3 region and start", v, 64'h1280);
    rd(8'h10, v); chk("R6 status accepting", v, 64'h0221_0000);
    wr(8'h18, 64'hAAAA_BBBB_1234_5678);
    chk("R4 pushed word", 64'(q_data), 64'h1234_5678);
    wr(8'h18, 64'h0000_0000_DEAD_BEEF);
    rd(8'h20, v); chk("R8 no error in session", v, 0);

    // R5 completion and drain
    wr(8'h08, 64'h3280);
    idle(3);
    rd(8'h10, v); chk("R6 status draining", v, 64'h0331_0000);
    rd(8'h08, v); chk("R5 complete set", v, 64'h3280);
    wr(8'h18, 64'h55);
    idle(1);
    rd(8'h20, v); chk("R8 data write while draining", v, 64'h08);
    wr(8'h20, 64'h08);
    rd(8'h20, v); chk("R7 clear by writing one", v, 0);
    q_empty = 1;
    hold = 0;
    for (int i = 0; i < 12; i++) begin
      rd(8'h08, v);
      if (v[12]) hold++;
    end
    chk("R5 start held for finish latency", 64'(hold), 64'd5);
    chk("R5 bits cleared, region kept", v, 64'h0280);
    rd(8'h10, v); chk("R6 status idle", v, 0);

    // R8 protocol misuse outside session
    wr(8'h08, 64'h2000);
    wr(8'h18, 64'h1);
    idle(1);
    rd(8'h20, v); chk("R8 complete without start", v, 64'h08);
    wr(8'h20, 64'h1F);

    // R7 sticky event flags
    ev_crc_err = 1; ev_overflow = 1;
    @(negedge clk);
    ev_crc_err = 0; ev_overflow = 0;
    rd(8'h20, v); chk("R7 crc and overflow set", v, 64'h12);
    wr(8'h20, 64'h02);
    rd(8'h20, v); chk("R7 partial clear", v, 64'h10);
    wr(8'h08, 64'h1);
    idle(2);
    wr(8'h08, 64'h0);
    idle(2);
    rd(8'h20, v); chk("R7 kept across engine reset", v, 64'h10);
    ev_overflow = 1;
    wr(8'h20, 64'h10);
    ev_overflow = 0;
    rd(8'h20, v); chk("R7 set wins over clear", v, 64'h10);
    ev_op_err = 1; ev_incompat = 1;
    @(negedge clk);
    ev_op_err = 0; ev_incompat = 0;
    rd(8'h20, v); chk("R7 operation and incompatible", v, 64'h15);
    wr(8'h20, 64'h1F);
    rd(8'h20, v); chk("R7 full clear", v, 0);

    // R2 abort during session
    q_empty = 0;
    wr(8'h08, 64'h1100);
    wr(8'h18, 64'h77);
    wr(8'h08, 64'h1);
    wr(8'h18, 64'h99);
    idle(1);
    rd(8'h08, v); chk("R2 session cleared by reset", v, 64'h11);
    rd(8'h20, v); chk("R8 data write under reset", v, 64'h08);
    wr(8'h08, 64'h0);
    idle(3);
    rd(8'h10, v); chk("R6 idle after abort", v, 0);

    idle(2);
    done = 1;
    summary();
    $finish;
  end
endmodule